// File: doc/BRIEF.md
# Register Rename Map Table

This block is the rename stage of a small out-of-order core. It renames one instruction per cycle. The instruction names two source logical registers and at most one destination logical register. For each source the block returns the physical tag that currently holds the value, and a ready bit. The ready bit is clear while a result for that tag is still outstanding. For the destination the block takes a fresh tag from the head of a free-tag FIFO. It writes that tag into the map entry and clears the entry's ready bit. Downstream logic uses the returned tags in place of the logical numbers.

Execution units broadcast the tag of each result they complete. Every entry that holds that tag becomes ready. A lookup made in the same cycle as the broadcast already reports ready. A flush input, raised for an exception or a mispredicted branch, marks every entry ready and keeps the tags. Commit logic hands retired tags back through a simple return port.

The control is a three-state machine:
- **FILL**: entered at reset. It loads the free list with one spare tag per cycle.
- **ACTIVE**: instructions are accepted.
- **DRAINED**: the free list is empty and renaming stalls.

The transitions are:
- **FILL to ACTIVE** after the last spare tag is loaded.
- **ACTIVE to DRAINED** when the last free tag is taken and none comes back in that cycle.
- **DRAINED to ACTIVE** when a tag is returned.

Top module: `rename_map`

## Requirements
- R1: After reset, `in_ready` stays low for NUM_PHYS-NUM_LOG cycles while the spare tags NUM_LOG..NUM_PHYS-1 are loaded into the free list in ascending order. From then on, logical register i maps to physical tag i and every entry is ready.
- R2: With no flush, each source port returns the tag stored for its logical register. Its ready bit is the stored ready bit.
- R3: An accepted instruction with `in_dst_we`=1 and a nonzero destination gets the free-list head on `dst_tag`. From the next cycle, that logical register maps to this tag and reads not ready.
- R4: A source that names the same logical register as the destination of the same instruction returns the mapping that held before that instruction.
- R5: Logical register 0 always returns tag 0 and ready. Renaming it consumes no free tag, changes nothing, and `dst_tag` reads 0.
- R6: A broadcast (`bc_valid`, `bc_tag`) sets ready from the next cycle in every entry that holds `bc_tag`. A lookup in the same cycle whose tag equals `bc_tag` already returns ready.
- R7: When a rename writes an entry in the same cycle as a broadcast of that entry's old tag, the entry ends holding the new tag, not ready.
- R8: `flush` forces `in_ready` low in that cycle. From the next cycle every entry is ready, and all tags are unchanged.
- R9: Free tags leave in the order in which they were loaded or returned. `in_ready` is low while the free list is empty. It rises the cycle after a tag is returned.
- R10: An accepted instruction with `in_dst_we`=0 consumes no free tag and leaves the map unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction accepted this cycle when high with in_valid |
| in_src1 | input | LOG_W | First source logical register |
| in_src2 | input | LOG_W | Second source logical register |
| in_dst | input | LOG_W | Destination logical register |
| in_dst_we | input | 1 | Instruction writes a destination |
| src1_tag | output | TAG_W | Physical tag for first source |
| src1_rdy | output | 1 | First source value available |
| src2_tag | output | TAG_W | Physical tag for second source |
| src2_rdy | output | 1 | Second source value available |
| dst_tag | output | TAG_W | New tag for destination (0 when none) |
| bc_valid | input | 1 | Completion broadcast valid |
| bc_tag | input | TAG_W | Tag of completed result |
| flush | input | 1 | Mark all entries ready |
| ret_valid | input | 1 | Tag returned to the free list |
| ret_tag | input | TAG_W | Returned tag |

## Verification
The bench builds the block with NUM_LOG=8 and NUM_PHYS=12, which leaves four spare tags. With so few spares, the free list empties after four renames. The DRAINED state and the recovery after a return are therefore reached many times, both in directed steps and in random traffic. With 12 tags, random broadcasts often hit a live mapping. They also often land in the same cycle as a lookup or a rename of the matching entry, which reaches the bypass and priority cases.

// File: rtl/rename_pkg.sv
package rename_pkg;
    typedef enum logic [1:0] {
        RN_FILL    = 2'd0,
        RN_ACTIVE  = 2'd1,
        RN_DRAINED = 2'd2
    } rn_state_e;
endpackage

// File: rtl/rn_free_list.sv
module rn_free_list #(
    parameter int NUM_PHYS = 80,
    parameter int TAG_W    = $clog2(NUM_PHYS),
    parameter int CNT_W    = $clog2(NUM_PHYS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [TAG_W-1:0] push_tag,
    input  logic             pop,
    output logic [TAG_W-1:0] head_tag,
    output logic [CNT_W-1:0] count
);
    localparam int DEPTH = NUM_PHYS;
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [TAG_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wr_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            slots[wr_ptr] <= push_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head_tag = slots[rd_ptr];
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
    parameter int NUM_LOG = 32,
    parameter int TAG_W   = 7,
    parameter int LOG_W   = $clog2(NUM_LOG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LOG_W-1:0] rd1_idx,
    input  logic [LOG_W-1:0] rd2_idx,
    output logic [TAG_W-1:0] rd1_tag,
    output logic             rd1_rdy,
    output logic [TAG_W-1:0] rd2_tag,
    output logic             rd2_rdy,
    input  logic             wr_en,
    input  logic [LOG_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             bc_valid,
    input  logic [TAG_W-1:0] bc_tag,
    input  logic             flush
);
    logic [TAG_W-1:0] tag_v [NUM_LOG];
    logic             rdy_v [NUM_LOG];

    for (genvar i = 0; i < NUM_LOG; i++) begin : g_ent
        if (i == 0) begin : g_zero
            // logical 0 is pinned to tag 0 and always ready
            assign tag_v[i] = '0;
            assign rdy_v[i] = 1'b1;
        end else begin : g_live
            logic [TAG_W-1:0] t_q;
            logic             r_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    t_q <= TAG_W'(i);
                    r_q <= 1'b1;
                end else if (wr_en && (wr_idx == LOG_W'(i))) begin
                    // a new producer outranks any broadcast of the old tag
                    t_q <= wr_tag;
                    r_q <= 1'b0;
                end else if (flush) begin
                    r_q <= 1'b1;
                end else if (bc_valid && (bc_tag == t_q)) begin
                    r_q <= 1'b1;
                end
            end
            assign tag_v[i] = t_q;
            assign rdy_v[i] = r_q;
        end
    end

    // reads see the state before this cycle's write; broadcast is bypassed
    always_comb begin
        rd1_tag = tag_v[rd1_idx];
        rd2_tag = tag_v[rd2_idx];
        rd1_rdy = rdy_v[rd1_idx] | (bc_valid && (bc_tag == rd1_tag));
        rd2_rdy = rdy_v[rd2_idx] | (bc_valid && (bc_tag == rd2_tag));
    end
endmodule

// File: rtl/rename_map.sv
module rename_map
    import rename_pkg::*;
#(
    parameter int NUM_LOG  = 32,
    parameter int NUM_PHYS = 80,
    parameter int TAG_W    = $clog2(NUM_PHYS),
    parameter int LOG_W    = $clog2(NUM_LOG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [LOG_W-1:0] in_src1,
    input  logic [LOG_W-1:0] in_src2,
    input  logic [LOG_W-1:0] in_dst,
    input  logic             in_dst_we,
    output logic [TAG_W-1:0] src1_tag,
    output logic             src1_rdy,
    output logic [TAG_W-1:0] src2_tag,
    output logic             src2_rdy,
    output logic [TAG_W-1:0] dst_tag,
    input  logic             bc_valid,
    input  logic [TAG_W-1:0] bc_tag,
    input  logic             flush,
    input  logic             ret_valid,
    input  logic [TAG_W-1:0] ret_tag
);
    localparam int CNT_W    = $clog2(NUM_PHYS + 1);
    localparam int LAST_TAG = NUM_PHYS - 1;

    rn_state_e        state_q, state_d;
    logic [TAG_W-1:0] fill_tag_q;
    logic [TAG_W-1:0] fl_head;
    logic [CNT_W-1:0] fl_count;
    logic             fl_push;
    logic [TAG_W-1:0] fl_push_tag;
    logic             fill_push;
    logic             fire;
    logic             dst_live;
    logic             rename_en;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RN_FILL;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         fill_tag_q <= TAG_W'(NUM_LOG);
        else if (fill_push) fill_tag_q <= fill_tag_q + 1'b1;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RN_FILL: begin
                if (fill_tag_q == TAG_W'(LAST_TAG)) state_d = RN_ACTIVE;
            end
            RN_ACTIVE: begin
                if (rename_en && !fl_push && (fl_count == CNT_W'(1)))
                    state_d = RN_DRAINED;
            end
            RN_DRAINED: begin
                if (fl_push) state_d = RN_ACTIVE;
            end
            default: state_d = RN_FILL;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        fill_push = 1'b0;
        in_ready  = 1'b0;
        unique case (state_q)
            RN_FILL:    fill_push = 1'b1;
            RN_ACTIVE:  in_ready  = !flush;
            RN_DRAINED: in_ready  = 1'b0;
            default:    in_ready  = 1'b0;
        endcase
    end

    assign fire        = in_valid && in_ready;
    assign dst_live    = in_dst_we && (in_dst != '0);
    assign rename_en   = fire && dst_live;
    assign fl_push     = fill_push || (ret_valid && (state_q != RN_FILL));
    assign fl_push_tag = fill_push ? fill_tag_q : ret_tag;
    assign dst_tag     = dst_live ? fl_head : '0;

    rn_free_list #(
        .NUM_PHYS (NUM_PHYS),
        .TAG_W    (TAG_W),
        .CNT_W    (CNT_W)
    ) u_free (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (fl_push),
        .push_tag (fl_push_tag),
        .pop      (rename_en),
        .head_tag (fl_head),
        .count    (fl_count)
    );

    rn_map_table #(
        .NUM_LOG (NUM_LOG),
        .TAG_W   (TAG_W),
        .LOG_W   (LOG_W)
    ) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd1_idx  (in_src1),
        .rd2_idx  (in_src2),
        .rd1_tag  (src1_tag),
        .rd1_rdy  (src1_rdy),
        .rd2_tag  (src2_tag),
        .rd2_rdy  (src2_rdy),
        .wr_en    (rename_en),
        .wr_idx   (in_dst),
        .wr_tag   (fl_head),
        .bc_valid (bc_valid),
        .bc_tag   (bc_tag),
        .flush    (flush)
    );
endmodule

// File: rtl/rename_map_chk.sv
module rename_map_chk
    import rename_pkg::*;
#(
    parameter int NUM_LOG  = 32,
    parameter int NUM_PHYS = 80,
    parameter int TAG_W    = $clog2(NUM_PHYS),
    parameter int LOG_W    = $clog2(NUM_LOG),
    parameter int CNT_W    = $clog2(NUM_PHYS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [LOG_W-1:0] in_src1,
    input logic [LOG_W-1:0] in_src2,
    input logic [LOG_W-1:0] in_dst,
    input logic             in_dst_we,
    input logic [TAG_W-1:0] src1_tag,
    input logic             src1_rdy,
    input logic [TAG_W-1:0] src2_tag,
    input logic             src2_rdy,
    input logic [TAG_W-1:0] dst_tag,
    input logic             bc_valid,
    input logic [TAG_W-1:0] bc_tag,
    input logic             flush,
    input rn_state_e        state_q,
    input logic [CNT_W-1:0] fl_count
);
    logic ren;
    assign ren = in_valid && in_ready && in_dst_we && (in_dst != '0);

    // R9
    drained_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RN_DRAINED) |-> (fl_count == '0));

    // R9
    empty_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_count == '0) |-> !in_ready);

    // R8
    flush_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !in_ready);

    // R8
    flush_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (src1_rdy && src2_rdy));

    // R5
    zero_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_src2 == '0) |-> ((src2_tag == '0) && src2_rdy));

    // R6
    bcast_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bc_valid && (bc_tag == src1_tag)) |-> src1_rdy);

    // R3
    rename_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ren |=> ((in_src1 != $past(in_dst)) || (src1_tag == $past(dst_tag))));
endmodule

bind rename_map rename_map_chk #(
    .NUM_LOG  (NUM_LOG),
    .NUM_PHYS (NUM_PHYS),
    .TAG_W    (TAG_W),
    .LOG_W    (LOG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_src1   (in_src1),
    .in_src2   (in_src2),
    .in_dst    (in_dst),
    .in_dst_we (in_dst_we),
    .src1_tag  (src1_tag),
    .src1_rdy  (src1_rdy),
    .src2_tag  (src2_tag),
    .src2_rdy  (src2_rdy),
    .dst_tag   (dst_tag),
    .bc_valid  (bc_valid),
    .bc_tag    (bc_tag),
    .flush     (flush),
    .state_q   (state_q),
    .fl_count  (fl_count)
);

// File: tb/sim_rename_map.sv
`timescale 1ns/1ps
module sim_rename_map;
    localparam int NL = 8;
    localparam int NP = 12;
    localparam int TW = 4;
    localparam int LW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [LW-1:0] in_src1 = '0, in_src2 = '0, in_dst = '0;
    logic          in_dst_we = 1'b0;
    logic [TW-1:0] src1_tag, src2_tag, dst_tag;
    logic          src1_rdy, src2_rdy;
    logic          bc_valid = 1'b0;
    logic [TW-1:0] bc_tag = '0;
    logic          flush = 1'b0;
    logic          ret_valid = 1'b0;
    logic [TW-1:0] ret_tag = '0;

    always #5 clk = ~clk;

    rename_map #(.NUM_LOG(NL), .NUM_PHYS(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_src1(in_src1), .in_src2(in_src2), .in_dst(in_dst), .in_dst_we(in_dst_we),
        .src1_tag(src1_tag), .src1_rdy(src1_rdy), .src2_tag(src2_tag), .src2_rdy(src2_rdy),
        .dst_tag(dst_tag), .bc_valid(bc_valid), .bc_tag(bc_tag), .flush(flush),
        .ret_valid(ret_valid), .ret_tag(ret_tag)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [TW-1:0] m_tag [NL];
    logic          m_rdy [NL];
    logic [TW-1:0] fq [$];
    logic [TW-1:0] pq [$];

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit exp_rdy(input int l, input bit bv, input int bt);
        if (l == 0) return 1'b1;
        return m_rdy[l] || (bv && (bt == int'(m_tag[l])));
    endfunction

    function automatic int exp_tag(input int l);
        return (l == 0) ? 0 : int'(m_tag[l]);
    endfunction

    // one cycle: called at a negedge, returns at the next negedge
    task automatic step(input string req, input bit v, input int s1, input int s2,
                        input int d, input bit we, input bit bv, input int bt,
                        input bit fl, input bit rv, input int rt);
        bit er, fire, live;
        in_valid = v; in_src1 = LW'(s1); in_src2 = LW'(s2); in_dst = LW'(d);
        in_dst_we = we; bc_valid = bv; bc_tag = TW'(bt); flush = fl;
        ret_valid = rv; ret_tag = TW'(rt);
        #1;
        er = (fq.size() > 0) && !fl;
        live = we && (d != 0);
        chk(req, "in_ready", int'(in_ready), int'(er));
        if (!fl) begin
            chk(req, "src1_tag", int'(src1_tag), exp_tag(s1));
            chk(req, "src1_rdy", int'(src1_rdy), int'(exp_rdy(s1, bv, bt)));
            chk(req, "src2_tag", int'(src2_tag), exp_tag(s2));
            chk(req, "src2_rdy", int'(src2_rdy), int'(exp_rdy(s2, bv, bt)));
        end
        if (er && live) chk(req, "dst_tag", int'(dst_tag), int'(fq[0]));
        if (!live) chk(req, "dst_tag_zero", int'(dst_tag), 0);
        fire = v && er;
        if (fl) begin
            for (int i = 1; i < NL; i++) m_rdy[i] = 1'b1;
        end else begin
            if (bv) for (int i = 1; i < NL; i++) if (int'(m_tag[i]) == bt) m_rdy[i] = 1'b1;
            if (fire && live) begin
                pq.push_back(m_tag[d]);
                m_tag[d] = fq.pop_front();
                m_rdy[d] = 1'b0;
            end
        end
        if (rv) fq.push_back(TW'(rt));
        @(negedge clk);
    endtask

    task automatic probe(input string req, input int l);
        step(req, 1'b0, l, (l + 1) % NL, 0, 1'b0, 1'b0, 0, 1'b0, 1'b0, 0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int rt;
        void'($urandom(32'd1234));
        for (int i = 0; i < NL; i++) begin m_tag[i] = TW'(i); m_rdy[i] = 1'b1; end
        for (int t = NL; t < NP; t++) fq.push_back(TW'(t));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: busy loading spares right after reset
        chk("R1", "in_ready_fill", int'(in_ready), 0);
        @(negedge clk);
        repeat (3) @(negedge clk);
        // R1: identity mapping, all ready
        for (int l = 0; l < NL; l++) probe("R1", l);

        // R4: source equals destination sees old mapping; R3: then new tag, not ready
        step("R4", 1, 3, 3, 3, 1, 0, 0, 0, 0, 0);
        probe("R3", 3);
        // R6: bypass of broadcast on lookup, then stored ready
        step("R6", 0, 3, 2, 0, 0, 1, int'(m_tag[3]), 0, 0, 0);
        probe("R6", 3);
        // R7: rename wins over broadcast of the old tag
        step("R7", 1, 1, 2, 4, 1, 1, 4, 0, 0, 0);
        probe("R7", 4);
        // R5: destination 0 consumes nothing
        step("R5", 1, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        probe("R5", 0);
        // R10: no destination write
        step("R10", 1, 5, 6, 5, 0, 0, 0, 0, 0, 0);
        probe("R10", 5);
        // R9: drain the free list
        while (fq.size() > 0) step("R9", 1, 1, 2, 6, 1, 0, 0, 0, 0, 0);
        step("R9", 1, 1, 2, 7, 1, 0, 0, 0, 0, 0);
        rt = int'(pq.pop_front());
        step("R9", 0, 1, 2, 7, 1, 0, 0, 0, 1, rt);
        step("R9", 1, 1, 2, 7, 1, 0, 0, 0, 0, 0);
        // R8: flush stalls and readies all, tags kept
        step("R8", 1, 6, 7, 2, 1, 0, 0, 1, 0, 0);
        for (int l = 0; l < NL; l++) probe("R8", l);

        // random traffic, mostly exercising R2
        for (int n = 0; n < 600; n++) begin
            bit rv;
            int rtg;
            rv = (pq.size() > 0) && ($urandom_range(2) == 0);
            rtg = 0;
            if (rv) rtg = int'(pq.pop_front());
            step("R2", $urandom_range(3) != 0, $urandom_range(NL - 1), $urandom_range(NL - 1),
                 $urandom_range(NL - 1), $urandom_range(4) != 0, $urandom_range(2) == 0,
                 $urandom_range(NP - 1), $urandom_range(29) == 0, rv, rtg);
        end
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule